// File: doc/BRIEF.md
# Two-level nested interrupt controller

This block arbitrates seventeen interrupt request lines for a small 8-bit CPU core. Software sets one enable bit and one priority bit per source, plus a single master enable. At every instruction boundary the core pulses a strobe, and the controller latches the masked request lines on that strobe. From the latched set it chooses at most one winner and offers it to the core as a request with a 16-bit service address.

When the core takes the request, it pulses an acknowledge. The controller then marks the winner's priority level as in service, forgets the latched request of the winner, and, for the four sources that hardware clears, sends a one-cycle clear strobe back to that source. A return pulse closes the innermost open level. New requests are then held back until the next instruction boundary, so the interrupted code makes progress. There are two levels. A high-priority source can interrupt low-priority service. Low-priority requests wait while low-priority service is open, and nothing interrupts high-priority service. Among candidates on the same level, the lowest source index wins, and the losers stay latched.

Top module: `nested_irq_ctl`

## Requirements
- R1: A write with `cfg_we` high stores `cfg_wdata` into the bank chosen by `cfg_sel`. Selects 0, 1 and 2 hold the enable bits: bank b bit k enables source 8b+k. Bit 7 of bank 2 is the master enable. Selects 3, 4 and 5 hold the priority bits in the same layout, with 1 meaning high. All bits are cleared by reset, and selects 6 and 7 store nothing.
- R2: `src_req` is captured only on a clock edge where `cyc_strobe` is high. Between captures, changes on `src_req` do not affect `irq_req`. The outcome of a capture appears on `irq_req` from the cycle after that edge.
- R3: A source whose enable bit is 0, or any source while the master enable is 0, is never requested.
- R4: While high-level service is open, `irq_req` stays low. While only low-level service is open, only high-priority candidates are requested. With no service open, a high candidate beats every low one.
- R5: Among candidates of the winning level, the lowest source index is requested. Each losing source stays latched and is requested after the winner is acknowledged and closed.
- R6: After an `irq_ret` pulse, `irq_req` stays low until the next capture edge, even if latched candidates exist.
- R7: `irq_vec` for source i is as follows. For i=0..3 it is 0x0003+8i. For i=4 and 5 it is 0x002B+8(i-4). For i=6..13 it is 0x003B+8(i-6). Source 14 gives 0x0083, source 15 gives 0x008B and source 16 gives 0x00B3.
- R8: An acknowledge of source 0..3 pulses bit i of `hw_clr` for exactly the cycle after the acknowledge. Acknowledges of sources 4..16 leave `hw_clr` at zero.
- R9: `irq_ack` while `irq_req` is high opens the winner's level (`lvl_hi` or `lvl_lo`) and drops that winner's latched request. `irq_ret` closes the high level if it is open, and otherwise closes the low level.
- R10: After reset, `irq_req`, `lvl_lo`, `lvl_hi` and `hw_clr` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_strobe | input | 1 | Instruction boundary; capture request lines |
| src_req | input | 17 | Request flags from the sources |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Configuration bank select |
| cfg_wdata | input | 8 | Configuration write data |
| irq_ack | input | 1 | Core takes the offered request |
| irq_ret | input | 1 | Core returns from a service routine |
| irq_req | output | 1 | Request to the core |
| irq_vec | output | 16 | Service address of the offered source |
| hw_clr | output | 17 | One-cycle clear strobes to hardware-cleared sources |
| lvl_lo | output | 1 | Low-level service open |
| lvl_hi | output | 1 | High-level service open |

## Verification
If the level tracker holds a wrong state, the fault shows on the first capture afterwards. A request is offered where service should block it, or it is missing where a high source should preempt. The level outputs diverge on the cycle after the acknowledge or return. A stale gap flag shows as a request appearing directly after a return, or as a missing request after the next boundary. A wrong latched-request bit shows as a repeated or lost service address on the next acknowledge. A misrouted clear strobe shows on `hw_clr` one cycle after the acknowledge.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;

    localparam int NSRC  = 17;
    localparam int IDXW  = $clog2(NSRC);
    localparam int VECW  = 16;
    localparam int NBANK = (NSRC + 1 + 7) / 8;
    localparam int SELW  = $clog2(2 * NBANK);
    localparam int GBIT  = 7;

    localparam logic [NSRC-1:0] HWCLR_MASK = NSRC'(17'h0000F);

    typedef enum logic {
        LVL_LO = 1'b0,
        LVL_HI = 1'b1
    } lvl_e;

    typedef struct packed {
        logic            valid;
        lvl_e            lvl;
        logic [IDXW-1:0] idx;
    } grant_t;

    function automatic logic [VECW-1:0] vec_of(input logic [IDXW-1:0] idx);
        int i;
        int v;
        i = int'(idx);
        if (i < 4)       v = 3 + 8 * i;
        else if (i < 6)  v = 'h2B + 8 * (i - 4);
        else if (i < 14) v = 'h3B + 8 * (i - 6);
        else if (i == 14) v = 'h83;
        else if (i == 15) v = 'h8B;
        else             v = 'hB3;
        return VECW'(v);
    endfunction

endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
    import irq_ctl_pkg::*;
#(
    parameter int N  = NSRC,
    parameter int NB = NBANK,
    parameter int SW = SELW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [SW-1:0] sel,
    input  logic [7:0]    wdata,
    output logic [N-1:0]  en,
    output logic [N-1:0]  pr,
    output logic          gen
);

    for (genvar i = 0; i < N; i++) begin : g_bit
        localparam int BANK = i / 8;
        localparam int POS  = i % 8;
        always_ff @(posedge clk) begin
            if (rst) begin
                en[i] <= 1'b0;
                pr[i] <= 1'b0;
            end else if (we) begin
                if (sel == SW'(BANK))      en[i] <= wdata[POS];
                if (sel == SW'(NB + BANK)) pr[i] <= wdata[POS];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                               gen <= 1'b0;
        else if (we && sel == SW'(NB - 1))     gen <= wdata[GBIT];
    end

endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
    parameter int N  = 17,
    parameter int IW = 5
) (
    input  logic [N-1:0]  cand,
    output logic          found,
    output logic [IW-1:0] idx
);

    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (cand[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end

endmodule

// File: rtl/irq_levels.sv
module irq_levels
    import irq_ctl_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cyc,
    input  logic ack_fire,
    input  lvl_e ack_lvl,
    input  logic ret,
    output logic lo_act,
    output logic hi_act,
    output logic hold
);

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_act <= 1'b0;
            hi_act <= 1'b0;
            hold   <= 1'b0;
        end else begin
            if (ret) begin
                if (hi_act) hi_act <= 1'b0;
                else        lo_act <= 1'b0;
            end else if (ack_fire) begin
                if (ack_lvl == LVL_HI) hi_act <= 1'b1;
                else                   lo_act <= 1'b1;
            end
            if (ret)      hold <= 1'b1;
            else if (cyc) hold <= 1'b0;
        end
    end

endmodule

// File: rtl/nested_irq_ctl.sv
module nested_irq_ctl
    import irq_ctl_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            cyc_strobe,
    input  logic [NSRC-1:0] src_req,
    input  logic            cfg_we,
    input  logic [SELW-1:0] cfg_sel,
    input  logic [7:0]      cfg_wdata,
    input  logic            irq_ack,
    input  logic            irq_ret,
    output logic            irq_req,
    output logic [VECW-1:0] irq_vec,
    output logic [NSRC-1:0] hw_clr,
    output logic            lvl_lo,
    output logic            lvl_hi
);

    logic [NSRC-1:0] en, pr, samp, win_oh;
    logic            gen, hold, ack_fire;
    logic            hi_found, lo_found;
    logic [IDXW-1:0] hi_idx, lo_idx;
    grant_t          grant;

    irq_cfg_regs #(.N(NSRC), .NB(NBANK), .SW(SELW)) u_cfg (
        .clk(clk), .rst(rst), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
        .en(en), .pr(pr), .gen(gen)
    );

    irq_pick #(.N(NSRC), .IW(IDXW)) u_pick_hi (
        .cand(samp & pr), .found(hi_found), .idx(hi_idx)
    );

    irq_pick #(.N(NSRC), .IW(IDXW)) u_pick_lo (
        .cand(samp & ~pr), .found(lo_found), .idx(lo_idx)
    );

    always_comb begin
        grant = '{valid: 1'b0, lvl: LVL_LO, idx: '0};
        if (!lvl_hi) begin
            if (hi_found)
                grant = '{valid: 1'b1, lvl: LVL_HI, idx: hi_idx};
            else if (!lvl_lo && lo_found)
                grant = '{valid: 1'b1, lvl: LVL_LO, idx: lo_idx};
        end
    end

    assign irq_req  = grant.valid && !hold;
    assign irq_vec  = vec_of(grant.idx);
    assign ack_fire = irq_ack && irq_req;
    assign win_oh   = NSRC'(1) << grant.idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            samp <= '0;
        end else if (cyc_strobe) begin
            samp <= (src_req & en & {NSRC{gen}}) & ~(ack_fire ? win_oh : '0);
        end else if (ack_fire) begin
            samp <= samp & ~win_oh;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) hw_clr <= '0;
        else     hw_clr <= ack_fire ? (win_oh & HWCLR_MASK) : '0;
    end

    irq_levels u_lvl (
        .clk(clk), .rst(rst), .cyc(cyc_strobe), .ack_fire(ack_fire),
        .ack_lvl(grant.lvl), .ret(irq_ret),
        .lo_act(lvl_lo), .hi_act(lvl_hi), .hold(hold)
    );

endmodule

// File: rtl/nested_irq_ctl_chk.sv
module nested_irq_ctl_chk
    import irq_ctl_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            irq_ack,
    input logic            irq_ret,
    input logic            irq_req,
    input logic [VECW-1:0] irq_vec,
    input logic [NSRC-1:0] hw_clr,
    input logic            lvl_lo,
    input logic            lvl_hi
);

    AST_HI_BLOCKS_ALL: assert property (@(posedge clk) disable iff (rst)
        lvl_hi |-> !irq_req);                                        // R4
    AST_LO_ONLY_BY_HI: assert property (@(posedge clk) disable iff (rst)
        (irq_ack && irq_req && lvl_lo) |=> lvl_hi);                  // R4
    AST_RET_GAP: assert property (@(posedge clk) disable iff (rst)
        irq_ret |=> !irq_req);                                       // R6
    AST_VEC_SLOT: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> (irq_vec[2:0] == 3'b011));                       // R7
    AST_CLR_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hw_clr));                                           // R8
    AST_CLR_HW_ONLY: assert property (@(posedge clk) disable iff (rst)
        (hw_clr & ~HWCLR_MASK) == '0);                               // R8
    AST_CLR_CAUSE: assert property (@(posedge clk) disable iff (rst)
        (|hw_clr) |-> $past(irq_ack && irq_req));                    // R8
    AST_ACK_OPENS: assert property (@(posedge clk) disable iff (rst)
        (irq_ack && irq_req) |=> (lvl_lo || lvl_hi));                // R9

endmodule

bind nested_irq_ctl nested_irq_ctl_chk u_chk (.*);

// File: tb/test_nested_irq_ctl.sv
module test_nested_irq_ctl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cyc_strobe = 1'b0;
    logic [16:0] src_req = '0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_sel = '0;
    logic [7:0]  cfg_wdata = '0;
    logic        irq_ack = 1'b0;
    logic        irq_ret = 1'b0;
    logic        irq_req;
    logic [15:0] irq_vec;
    logic [16:0] hw_clr;
    logic        lvl_lo, lvl_hi;

    int tests = 0;
    int fails = 0;

    always #5 clk = ~clk;

    nested_irq_ctl i_nested_irq_ctl (
        .clk(clk), .rst(rst), .cyc_strobe(cyc_strobe), .src_req(src_req),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .irq_ack(irq_ack), .irq_ret(irq_ret), .irq_req(irq_req),
        .irq_vec(irq_vec), .hw_clr(hw_clr), .lvl_lo(lvl_lo), .lvl_hi(lvl_hi)
    );

    function automatic logic [31:0] exp_vec(input int i);
        if (i < 4)        return 32'(3 + 8 * i);
        else if (i < 6)   return 32'(43 + 8 * (i - 4));
        else if (i < 14)  return 32'(59 + 8 * (i - 6));
        else if (i == 14) return 32'd131;
        else if (i == 15) return 32'd139;
        else              return 32'd179;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] sel, input logic [7:0] d);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic set_cfg(input logic [16:0] en, input logic [16:0] pr, input logic g);
        logic [23:0] e24, p24;
        e24 = {7'd0, en};
        p24 = {7'd0, pr};
        e24[23] = g;
        for (int b = 0; b < 3; b++) begin
            wr(3'(b), e24[8*b +: 8]);
            wr(3'(3 + b), p24[8*b +: 8]);
        end
    endtask

    task automatic strobe();
        cyc_strobe = 1'b1; @(negedge clk); cyc_strobe = 1'b0;
    endtask
    task automatic ack();
        irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
    endtask
    task automatic ret();
        irq_ret = 1'b1; @(negedge clk); irq_ret = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual running expected finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        chk("R10 irq_req", 32'(irq_req), 0);
        chk("R10 levels", {30'd0, lvl_hi, lvl_lo}, 0);
        chk("R10 hw_clr", 32'(hw_clr), 0);
        // R1 configuration is zero after reset: a request is not taken
        src_req = 17'h1FFFF;
        strobe();
        chk("R1 reset config masks", 32'(irq_req), 0);
        src_req = '0;

        // Sweep every source, alternating priority (R1 R7 R8 R9)
        for (int i = 0; i < 17; i++) begin
            logic hi;
            hi = (i % 2) == 1;
            set_cfg(17'(1) << i, hi ? (17'(1) << i) : 17'd0, 1'b1);
            src_req = 17'(1) << i;
            strobe();
            chk("R1 R2 request raised", 32'(irq_req), 1);
            chk("R7 vector", 32'(irq_vec), exp_vec(i));
            ack();
            chk("R8 hw_clr", 32'(hw_clr), (i < 4) ? 32'(1) << i : 0);
            chk("R9 level opened", {30'd0, lvl_hi, lvl_lo}, hi ? 2 : 1);
            chk("R9 winner dropped", 32'(irq_req), 0);
            @(negedge clk);
            chk("R8 hw_clr single cycle", 32'(hw_clr), 0);
            src_req = '0;
            ret();
            chk("R9 level closed", {30'd0, lvl_hi, lvl_lo}, 0);
            strobe();
        end

        // R3 master and individual enables
        set_cfg(17'h1FFFF, 17'd0, 1'b0);
        src_req = 17'h4;
        strobe();
        chk("R3 master off", 32'(irq_req), 0);
        set_cfg(17'h1FFFB, 17'd0, 1'b1);
        strobe();
        chk("R3 source off", 32'(irq_req), 0);
        set_cfg(17'h1FFFF, 17'd0, 1'b1);
        strobe();
        chk("R3 enabled", 32'(irq_vec), exp_vec(2));
        ack();
        src_req = '0;
        ret();
        strobe();

        // R2 capture only on strobe
        src_req = 17'(1) << 6;
        @(negedge clk); @(negedge clk);
        chk("R2 no capture between strobes", 32'(irq_req), 0);
        strobe();
        chk("R2 captured", 32'(irq_req), 1);
        src_req = '0;
        @(negedge clk);
        chk("R2 held between strobes", 32'(irq_vec), exp_vec(6));
        strobe();
        chk("R2 recapture clears", 32'(irq_req), 0);

        // R5 ties and R6 gap
        src_req = (17'(1) << 5) | (17'(1) << 9) | (17'(1) << 14);
        strobe();
        chk("R5 lowest index first", 32'(irq_vec), exp_vec(5));
        ack();
        chk("R8 no clear for source 5", 32'(hw_clr), 0);
        src_req[5] = 1'b0;
        ret();
        chk("R6 gap after return", 32'(irq_req), 0);
        @(negedge clk);
        chk("R6 gap until boundary", 32'(irq_req), 0);
        strobe();
        chk("R5 second pending", 32'(irq_vec), exp_vec(9));
        ack();
        src_req[9] = 1'b0;
        ret();
        strobe();
        chk("R5 third pending", 32'(irq_vec), exp_vec(14));
        ack();
        src_req = '0;
        ret();
        strobe();
        chk("R5 all served", 32'(irq_req), 0);

        // R4 nesting
        set_cfg(17'h1FFFF, (17'(1) << 12) | (17'(1) << 13), 1'b1);
        src_req = (17'(1) << 7) | (17'(1) << 8);
        strobe();
        chk("R4 low taken", 32'(irq_vec), exp_vec(7));
        ack();
        chk("R4 low blocks low", 32'(irq_req), 0);
        src_req = 17'(1) << 8;
        strobe();
        chk("R4 low over low refused", 32'(irq_req), 0);
        src_req = (17'(1) << 8) | (17'(1) << 12);
        strobe();
        chk("R4 high preempts low", 32'(irq_vec), exp_vec(12));
        ack();
        chk("R9 both levels", {30'd0, lvl_hi, lvl_lo}, 3);
        src_req = (17'(1) << 8) | (17'(1) << 13);
        strobe();
        chk("R4 high blocks high", 32'(irq_req), 0);
        ret();
        chk("R9 return closes high first", {30'd0, lvl_hi, lvl_lo}, 1);
        strobe();
        chk("R4 high preempts low again", 32'(irq_vec), exp_vec(13));
        ack();
        src_req = 17'(1) << 8;
        ret();
        strobe();
        chk("R4 low still blocked", 32'(irq_req), 0);
        ret();
        chk("R9 low closed", {30'd0, lvl_hi, lvl_lo}, 0);
        strobe();
        chk("R4 pending low served", 32'(irq_vec), exp_vec(8));
        ack();
        src_req = '0;
        ret();
        strobe();
        chk("R9 idle at end", {30'd0, lvl_hi, lvl_lo, irq_req}, 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule